// File: doc/BRIEF.md
# Two-Rail Regulator Start-Up Sequencer

This block is the digital start-up controller for a regulator with two outputs, a core rail and a north-bridge rail. While the qualified enable input and the supply-good flag are both high, it runs a start-up sequence. It first latches the operating mode, the phase count read from two strap inputs and the two target voltage codes. It then waits for a fixed settling delay. After the delay it ramps a digital reference for each active rail toward its target at a fixed slope. Voltages are unsigned codes in quarter-millivolt units. Time advances on an internal 1 µs tick derived from the clock.

Each rail has a driver-enable output that takes account of pre-bias. If the rail's digitized feedback already sits above the rising reference, the drivers stay off until the reference passes the feedback. Rails whose feedback never falls below the reference have their drivers switched on when start-up ends. Power-good rises once every active rail has reached its target. In parallel mode only the core rail is sequenced. Dropping enable or the supply-good flag returns everything to the idle state on the next clock.

Top module: `vr_softstart_seq`

## Requirements
- R1: While `en_i` or `por_ok_i` is low, at every following clock edge both references are 0, both driver enables are 0, `pgood_o` is 0, `mode_serial_o` is 0 and `phase_cnt_o` is 0.
- R2: At the first clock edge where `en_i` and `por_ok_i` are both high, `mode_serial_o` takes the value of `mode_sel_i`: 1 means serial mode and 0 means parallel mode. It then holds that value while both inputs stay high, whatever `mode_sel_i` does.
- R3: At that same edge, `phase_cnt_o` is loaded as a binary count. If `strap3_i` and `strap4_i` are both 1, the count is 2. If only `strap4_i` is 1, the count is 3. In every other case the count is 4. The count then holds while the block is running.
- R4: Both target codes are captured at that same edge. Later changes on `core_target_i` and `nb_target_i` have no effect on the ramp or its end value.
- R5: In parallel mode, `nb_ref_o` and `nb_drv_en_o` stay 0, and `pgood_o` depends only on the core rail.
- R6: A start-up edge is counted as edge 0. The references stay at 0 through clock edge DELAY_TICKS×CLK_PER_TICK.
- R7: After the delay, each active reference rises by STEP codes per tick, clamped at its target. The reference equals min(k×STEP, target) after edge (DELAY_TICKS+k)×CLK_PER_TICK.
- R8: `pgood_o` rises at edge (DELAY_TICKS+K)×CLK_PER_TICK+1. K is the largest ceil(target/STEP) over the active rails, and is 0 when every active target is 0.
- R9: During the ramp, a rail's driver enable rises only at the edge after its reference exceeds its feedback code. Once high, it stays high until shutdown.
- R10: A rail whose driver enable is still low when start-up ends has it forced high at the edge where `pgood_o` rises.
- R11: If `en_i` or `por_ok_i` drops while the block is running, all outputs are cleared at the next clock edge.
- R12: A target of 0 counts as reached as soon as the ramp phase begins, so that rail never delays `pgood_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Qualified enable |
| por_ok_i | input | 1 | Supply power-on-reset satisfied |
| strap3_i | input | 1 | Phase strap for the third phase |
| strap4_i | input | 1 | Phase strap for the fourth phase |
| mode_sel_i | input | 1 | Mode select, 1 = serial, 0 = parallel |
| core_target_i | input | CODE_W | Core target code |
| nb_target_i | input | CODE_W | North-bridge target code |
| core_fb_i | input | CODE_W | Digitized core feedback |
| nb_fb_i | input | CODE_W | Digitized north-bridge feedback |
| core_ref_o | output | CODE_W | Core reference ramp |
| nb_ref_o | output | CODE_W | North-bridge reference ramp |
| core_drv_en_o | output | 1 | Core driver enable |
| nb_drv_en_o | output | 1 | North-bridge driver enable |
| mode_serial_o | output | 1 | Latched mode |
| phase_cnt_o | output | 3 | Latched phase count |
| pgood_o | output | 1 | Power-good |

## Verification
The hardest situation to bring about is the crossover of a pre-biased rail. The driver enable must stay low while the reference climbs toward a fixed feedback code, and then rise exactly one edge after the reference passes it. A second case has feedback held above the target, so the enable only comes on through the end-of-start-up force. The bench holds `core_fb_i` at a constant code between two ramp steps and compares every sampled driver enable against the reference seen one edge earlier. A separate run keeps the feedback above the target throughout and checks that the enable and power-good rise on the same edge.

// File: rtl/vr_ss_pkg.sv
package vr_ss_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DELAY = 2'd1,
    ST_RAMP  = 2'd2,
    ST_DONE  = 2'd3
  } ss_state_e;
endpackage

// File: rtl/vr_ss_tick.sv
// Divides the clock down to one pulse per time tick while running.
module vr_ss_tick #(
  parameter int CLK_PER_TICK = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = '0;
    if (run_i && (cnt_q != LAST)) cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/vr_ss_fsm.sv
// Sequencing state: idle, settling delay, ramp, complete.
module vr_ss_fsm
  import vr_ss_pkg::*;
#(
  parameter int DELAY_TICKS = 100
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active_i,
  input  logic      tick_i,
  input  logic      all_done_i,
  output ss_state_e state_o,
  output logic      load_o,
  output logic      finish_o
);
  localparam int DW = $clog2(DELAY_TICKS + 1);
  localparam logic [DW-1:0] DLAST = DW'(DELAY_TICKS - 1);

  ss_state_e     state_q, state_n;
  logic [DW-1:0] dcnt_q, dcnt_n;

  always_comb begin
    state_n  = state_q;
    dcnt_n   = dcnt_q;
    load_o   = 1'b0;
    finish_o = 1'b0;
    if (!active_i) begin
      state_n = ST_OFF;
      dcnt_n  = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          load_o  = 1'b1;
          state_n = ST_DELAY;
          dcnt_n  = '0;
        end
        ST_DELAY: begin
          if (tick_i) begin
            if (dcnt_q == DLAST) begin
              state_n = ST_RAMP;
              dcnt_n  = '0;
            end else begin
              dcnt_n = dcnt_q + DW'(1);
            end
          end
        end
        ST_RAMP: begin
          if (all_done_i) begin
            state_n  = ST_DONE;
            finish_o = 1'b1;
          end
        end
        default: state_n = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      dcnt_q  <= dcnt_n;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/vr_ss_rail.sv
// One rail: captured target, clamped reference ramp, pre-bias driver gate.
module vr_ss_rail #(
  parameter int CODE_W = 16,
  parameter int STEP   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic              rail_en_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic [CODE_W-1:0] fb_i,
  input  logic              step_i,
  input  logic              ramp_i,
  input  logic              finish_i,
  output logic [CODE_W-1:0] ref_o,
  output logic [CODE_W-1:0] tgt_o,
  output logic              drv_en_o,
  output logic              done_o
);
  logic [CODE_W-1:0] tgt_q, tgt_n, ref_q, ref_n;
  logic              en_q, en_n, drv_q, drv_n;
  logic [CODE_W:0]   sum;

  assign sum = {1'b0, ref_q} + (CODE_W+1)'(STEP);

  always_comb begin
    tgt_n = tgt_q;
    ref_n = ref_q;
    en_n  = en_q;
    drv_n = drv_q;
    if (clear_i) begin
      tgt_n = '0;
      ref_n = '0;
      en_n  = 1'b0;
      drv_n = 1'b0;
    end else if (load_i) begin
      en_n  = rail_en_i;
      tgt_n = rail_en_i ? target_i : '0;
      ref_n = '0;
      drv_n = 1'b0;
    end else if (en_q) begin
      if (step_i) begin
        if (sum >= {1'b0, tgt_q}) ref_n = tgt_q;
        else                      ref_n = sum[CODE_W-1:0];
      end
      if ((ramp_i && (ref_q > fb_i)) || finish_i) drv_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      ref_q <= '0;
      en_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      tgt_q <= tgt_n;
      ref_q <= ref_n;
      en_q  <= en_n;
      drv_q <= drv_n;
    end
  end

  assign ref_o    = ref_q;
  assign tgt_o    = tgt_q;
  assign drv_en_o = drv_q;
  assign done_o   = !en_q || (ref_q == tgt_q);
endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
  import vr_ss_pkg::*;
#(
  parameter int CODE_W       = 16,
  parameter int STEP         = 13,
  parameter int CLK_PER_TICK = 100,
  parameter int DELAY_TICKS  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              por_ok_i,
  input  logic              strap3_i,
  input  logic              strap4_i,
  input  logic              mode_sel_i,
  input  logic [CODE_W-1:0] core_target_i,
  input  logic [CODE_W-1:0] nb_target_i,
  input  logic [CODE_W-1:0] core_fb_i,
  input  logic [CODE_W-1:0] nb_fb_i,
  output logic [CODE_W-1:0] core_ref_o,
  output logic [CODE_W-1:0] nb_ref_o,
  output logic              core_drv_en_o,
  output logic              nb_drv_en_o,
  output logic              mode_serial_o,
  output logic [2:0]        phase_cnt_o,
  output logic              pgood_o
);
  localparam int NUM_RAILS = 2;

  ss_state_e         state;
  logic              active, running, tick, load, finish, all_done;
  logic              mode_q, mode_n;
  logic [2:0]        phase_q, phase_n, phase_sel;
  logic [CODE_W-1:0] tgt_in  [NUM_RAILS];
  logic [CODE_W-1:0] fb_in   [NUM_RAILS];
  logic [CODE_W-1:0] ref_w   [NUM_RAILS];
  logic [CODE_W-1:0] tgt_w   [NUM_RAILS];
  logic [NUM_RAILS-1:0] rail_en, drv_w, done_w;
  logic [CODE_W-1:0] core_tgt_w;

  assign active  = en_i && por_ok_i;
  assign running = (state != ST_OFF);

  vr_ss_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(running && active), .tick_o(tick)
  );

  vr_ss_fsm #(.DELAY_TICKS(DELAY_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .active_i(active), .tick_i(tick),
    .all_done_i(all_done), .state_o(state), .load_o(load), .finish_o(finish)
  );

  // Phase strap decode
  always_comb begin
    if (strap3_i && strap4_i) phase_sel = 3'd2;
    else if (strap4_i)        phase_sel = 3'd3;
    else                      phase_sel = 3'd4;
  end

  always_comb begin
    mode_n  = mode_q;
    phase_n = phase_q;
    if (!active) begin
      mode_n  = 1'b0;
      phase_n = 3'd0;
    end else if (load) begin
      mode_n  = mode_sel_i;
      phase_n = phase_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      phase_q <= 3'd0;
    end else begin
      mode_q  <= mode_n;
      phase_q <= phase_n;
    end
  end

  // Rail 0 is the core rail, always sequenced; rail 1 only in serial mode.
  assign tgt_in[0]  = core_target_i;
  assign tgt_in[1]  = nb_target_i;
  assign fb_in[0]   = core_fb_i;
  assign fb_in[1]   = nb_fb_i;
  assign rail_en[0] = 1'b1;
  assign rail_en[1] = mode_sel_i;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    vr_ss_rail #(.CODE_W(CODE_W), .STEP(STEP)) u_rail (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (!active),
      .load_i   (load),
      .rail_en_i(rail_en[g]),
      .target_i (tgt_in[g]),
      .fb_i     (fb_in[g]),
      .step_i   (tick && (state == ST_RAMP)),
      .ramp_i   (state == ST_RAMP),
      .finish_i (finish),
      .ref_o    (ref_w[g]),
      .tgt_o    (tgt_w[g]),
      .drv_en_o (drv_w[g]),
      .done_o   (done_w[g])
    );
  end

  assign all_done      = &done_w;
  assign core_tgt_w    = tgt_w[0];
  assign core_ref_o    = ref_w[0];
  assign nb_ref_o      = ref_w[1];
  assign core_drv_en_o = drv_w[0];
  assign nb_drv_en_o   = drv_w[1];
  assign mode_serial_o = mode_q;
  assign phase_cnt_o   = phase_q;
  assign pgood_o       = (state == ST_DONE);
endmodule

// File: rtl/vr_ss_checker.sv
module vr_ss_checker #(
  parameter int CODE_W = 16,
  parameter int STEP   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              por_ok_i,
  input logic              running_i,
  input logic              mode_serial_o,
  input logic [CODE_W-1:0] core_ref_o,
  input logic [CODE_W-1:0] nb_ref_o,
  input logic [CODE_W-1:0] core_fb_i,
  input logic              core_drv_en_o,
  input logic              nb_drv_en_o,
  input logic              pgood_o,
  input logic [CODE_W-1:0] core_tgt_i
);
  a_r11_clear_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && por_ok_i) |=> (core_ref_o == '0 && nb_ref_o == '0 && !core_drv_en_o
                             && !nb_drv_en_o && !pgood_o && !mode_serial_o));

  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running_i && en_i && por_ok_i) |=> $stable(mode_serial_o));

  a_r7_ref_slope: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && por_ok_i) |=> (core_ref_o >= $past(core_ref_o))
                           && ((core_ref_o - $past(core_ref_o)) <= CODE_W'(STEP)));

  a_r5_nb_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_serial_o |-> (nb_ref_o == '0 && !nb_drv_en_o));

  a_r8_pgood_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> (core_ref_o == core_tgt_i));

  a_r10_drv_with_pgood: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> core_drv_en_o);

  a_r9_drv_crossover: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_drv_en_o) && !pgood_o) |-> ($past(core_ref_o) > $past(core_fb_i)));
endmodule

bind vr_softstart_seq vr_ss_checker #(.CODE_W(CODE_W), .STEP(STEP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .por_ok_i     (por_ok_i),
  .running_i    (running),
  .mode_serial_o(mode_serial_o),
  .core_ref_o   (core_ref_o),
  .nb_ref_o     (nb_ref_o),
  .core_fb_i    (core_fb_i),
  .core_drv_en_o(core_drv_en_o),
  .nb_drv_en_o  (nb_drv_en_o),
  .pgood_o      (pgood_o),
  .core_tgt_i   (core_tgt_w)
);

// File: tb/vr_softstart_seq_tb.sv
module vr_softstart_seq_tb;
  localparam int CW = 16;
  localparam int ST = 13;
  localparam int CPT = 4;
  localparam int DLY = 5;

  typedef struct packed {
    logic          mode;
    logic          s3;
    logic          s4;
    logic [CW-1:0] core_t;
    logic [CW-1:0] nb_t;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 16'd400, 16'd260},
    '{1'b0, 1'b0, 1'b1, 16'd130, 16'd999},
    '{1'b1, 1'b1, 1'b1, 16'd26,  16'd52},
    '{1'b1, 1'b1, 1'b0, 16'd0,   16'd13},
    '{1'b1, 1'b0, 1'b0, 16'd0,   16'd0},
    '{1'b0, 1'b1, 1'b1, 16'd0,   16'd500}
  };

  logic clk, rst_n, en, por, s3, s4, msel;
  logic [CW-1:0] ct, nt, cfb, nfb;
  logic [CW-1:0] cref, nref;
  logic cdrv, ndrv, mser, pg;
  logic [2:0] ph;
  int checks, errors, edge_n;

  vr_softstart_seq #(.CODE_W(CW), .STEP(ST), .CLK_PER_TICK(CPT), .DELAY_TICKS(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .por_ok_i(por), .strap3_i(s3), .strap4_i(s4),
    .mode_sel_i(msel), .core_target_i(ct), .nb_target_i(nt), .core_fb_i(cfb), .nb_fb_i(nfb),
    .core_ref_o(cref), .nb_ref_o(nref), .core_drv_en_o(cdrv), .nb_drv_en_o(ndrv),
    .mode_serial_o(mser), .phase_cnt_o(ph), .pgood_o(pg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ticks_for(input int t);
    return (t + ST - 1) / ST;
  endfunction

  task automatic next_edge();
    @(posedge clk);
    #1;
    edge_n++;
  endtask

  task automatic start_run(input logic m, input logic a3, input logic a4,
                           input int c_t, input int n_t);
    @(negedge clk);
    msel = m; s3 = a3; s4 = a4; ct = CW'(c_t); nt = CW'(n_t);
    en = 1'b1; por = 1'b1;
    @(posedge clk);
    #1;
    edge_n = 0;
  endtask

  task automatic stop_run();
    @(negedge clk);
    en = 1'b0;
    next_edge();
  endtask

  function automatic int idle_word();
    return int'(cref) + int'(nref) + int'(cdrv) + int'(ndrv) + int'(pg) + int'(mser) + int'(ph);
  endfunction

  initial begin
    int guard;
    guard = 0;
    forever begin
      @(posedge clk);
      guard++;
      if (guard > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", guard, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; errors = 0; edge_n = 0;
    rst_n = 1'b0; en = 1'b0; por = 1'b0; s3 = 1'b0; s4 = 1'b0; msel = 1'b0;
    ct = '0; nt = '0; cfb = '0; nfb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset idle", idle_word(), 0);

    // R1: enable without supply-good stays idle
    @(negedge clk);
    en = 1'b1; por = 1'b0; msel = 1'b1; ct = 16'd200;
    repeat (60) @(posedge clk);
    #1;
    chk("R1 no por idle", idle_word(), 0);
    @(negedge clk);
    en = 1'b0;

    // Table of start-ups
    for (int v = 0; v < NV; v++) begin
      int k, exp_ph, guard_c;
      vec_t x;
      x = VECS[v];
      exp_ph = (x.s3 && x.s4) ? 2 : (x.s4 ? 3 : 4);
      k = ticks_for(int'(x.core_t));
      if (x.mode && ticks_for(int'(x.nb_t)) > k) k = ticks_for(int'(x.nb_t));
      start_run(x.mode, x.s3, x.s4, int'(x.core_t), int'(x.nb_t));
      chk("R2 mode latch", int'(mser), int'(x.mode));
      chk("R3 phase count", int'(ph), exp_ph);
      guard_c = 0;
      while (!pg && guard_c < 2000) begin
        next_edge();
        guard_c++;
      end
      chk("R8 R12 pgood edge", edge_n, (DLY + k) * CPT + 1);
      chk("R7 core final", int'(cref), int'(x.core_t));
      chk("R5 nb final", int'(nref), x.mode ? int'(x.nb_t) : 0);
      chk("R10 core drv", int'(cdrv), 1);
      chk("R5 nb drv", int'(ndrv), int'(x.mode));
      stop_run();
      chk("R11 clear after drop", idle_word(), 0);
    end

    // R6 R7 delay and slope, with R4 and R2 hold
    start_run(1'b1, 1'b0, 1'b0, 400, 0);
    while (edge_n < DLY * CPT) next_edge();
    chk("R6 ref zero through delay", int'(cref), 0);
    next_edge();
    chk("R6 ref zero after delay edge", int'(cref), 0);
    while (edge_n < (DLY + 1) * CPT) next_edge();
    chk("R7 first step", int'(cref), ST);
    while (edge_n < (DLY + 2) * CPT) next_edge();
    chk("R7 second step", int'(cref), 2 * ST);
    @(negedge clk);
    ct = 16'd50; msel = 1'b0; s4 = 1'b1;
    #1;
    while (!pg && edge_n < 1000) next_edge();
    chk("R4 target held", int'(cref), 400);
    chk("R2 mode held", int'(mser), 1);
    chk("R3 phase held", int'(ph), 4);
    stop_run();

    // R9 pre-bias crossover at fixed feedback 100
    begin
      int prev_ref, bad;
      logic seen_high;
      bad = 0; seen_high = 1'b0;
      cfb = 16'd100;
      start_run(1'b0, 1'b0, 0, 400, 0);
      prev_ref = int'(cref);
      while (!pg && edge_n < 1000) begin
        next_edge();
        if (!pg) begin
          if ((prev_ref > 100) != cdrv) bad++;
          if (cdrv) seen_high = 1'b1;
        end
        prev_ref = int'(cref);
      end
      chk("R9 drv follows crossover", bad, 0);
      chk("R9 drv rose in ramp", int'(seen_high), 1);
      stop_run();
    end

    // R10 feedback above target: drivers forced with power-good
    begin
      int early;
      early = 0;
      cfb = 16'd1000;
      start_run(1'b0, 1'b0, 1'b0, 400, 0);
      while (!pg && edge_n < 1000) begin
        next_edge();
        if (!pg && cdrv) early++;
      end
      chk("R10 drv low before end", early, 0);
      chk("R10 drv forced at end", int'(cdrv), 1);
      stop_run();
      cfb = '0;
    end

    // R11 supply-good drop mid-ramp
    start_run(1'b1, 1'b0, 1'b0, 400, 300);
    while (edge_n < (DLY + 5) * CPT) next_edge();
    chk("R11 ramping before drop", int'(cref), 5 * ST);
    @(negedge clk);
    por = 1'b0;
    next_edge();
    chk("R11 clear after por drop", idle_word(), 0);
    @(negedge clk);
    en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule